// File: doc/BRIEF.md
# Opcode Page Stack Controller

This block tracks which opcode namespace ("page") the compressed-instruction decoder uses. The selection is a small stack. Each level holds a 3-bit page number and a 4-bit activation length. The top level is the live page, and an empty stack means the default page (code 0). Commands push a new level, drop one level, or clear the whole stack back to the default page.

A counted level loses one unit of length each time an instruction retires. It is removed by itself once its count runs out. A length of 15 marks a level as permanent: retirement never ages it, and only a command removes it. A taken branch ends every counted activation. The stack is cut back to the run of permanent levels that starts at the bottom.

The top level can be read and overwritten as a 7-bit control register, so software can save and restore the live selection across calls. One action takes effect per clock, chosen by a fixed priority.

Top module: `opcode_page_stack`

## Requirements
- R1: While `rstN` is low, the stack is emptied and the sticky overflow flag is cleared. After reset, `depth`, `curPage`, `csrRdData` and `overflow` all read 0.
- R2: A push command (`cmdOp`=1) on a stack holding fewer than 4 levels places {`cmdPage`,`cmdLen`} on top, and `depth` rises by one on the next cycle. The stack never holds more than 4 levels.
- R3: A push on a full stack leaves every level and `depth` unchanged and sets `overflow`. `overflow` then stays 1 until `rstN` is asserted; a clear command does not reset it.
- R4: A pop command (`cmdOp`=2) removes exactly one level and exposes the level beneath it unchanged. A pop on an empty stack has no effect.
- R5: A clear command (`cmdOp`=3) empties the stack in one cycle, so `curPage` returns to the default page 0.
- R6: When an instruction retires (`retire`=1) and the top length is between 2 and 14, the top length drops by one. When the top length is 0 or 1, the top level is popped. Levels below the top are never aged.
- R7: A top level of length 15 is unchanged by any number of retirements.
- R8: A taken branch sets `depth` to the number of consecutive length-15 levels counted from the bottom (slot 0). The levels that remain are not changed.
- R9: `csrRdData` shows the top level with the page in bits [6:4] and the length in bits [3:0], and reads 0 when the stack is empty. `curPage` equals `csrRdData[6:4]`. A write (`csrWrEn`=1) replaces the top level with `csrWrData`. A write on an empty stack changes nothing.
- R10: Each cycle performs one action, in this priority: a command (`cmdOp`≠0); otherwise a register write; otherwise a taken branch; otherwise a retirement. The action performed matches the rule for that action in R2–R9, and the other inputs that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdOp | input | 2 | 0 none, 1 push, 2 pop, 3 clear |
| cmdPage | input | 3 | Page number for a push |
| cmdLen | input | 4 | Activation length for a push (15 = permanent) |
| retire | input | 1 | An instruction retired this cycle |
| branchTaken | input | 1 | A taken branch retired this cycle |
| csrWrEn | input | 1 | Write the top level from `csrWrData` |
| csrWrData | input | 7 | {page[2:0], length[3:0]} to write |
| curPage | output | 3 | Active page, 0 when the stack is empty |
| csrRdData | output | 7 | {page, length} of the top level, 0 when empty |
| depth | output | 3 | Number of occupied levels (0 to 4) |
| overflow | output | 1 | Sticky flag: a push arrived on a full stack |

## Verification
Directed sequences build stacks whose levels mix permanent and counted lengths. They show that ageing touches only the top and that a branch stops at the first counted level from the bottom, not at the top. They also cover the edge cases where count-based and permanent handling part ways: length 0 versus 1 versus 2, a full stack, an empty stack, and register writes while empty. Seeded random cycles then drive several inputs in the same cycle. Any error in the action priority shows up as a mismatch against a reference model of the stack kept in the bench.

// File: rtl/opage_pkg.sv
package opage_pkg;
  localparam int PAGE_W = 3;
  localparam int LEN_W  = 4;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_PUSH  = 2'd1,
    CMD_POP   = 2'd2,
    CMD_CLEAR = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [LEN_W-1:0]  len;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  // one action strobe per cycle at most
  typedef struct packed {
    logic clearAll;
    logic push;
    logic popOne;
    logic ovfSet;
    logic csrWr;
    logic cutBranch;
    logic decTop;
    logic popExpired;
  } strobe_t;
endpackage

// File: rtl/opage_ctrl.sv
module opage_ctrl
  import opage_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cmdOp,
  input  logic               csrWrEn,
  input  logic               branchTaken,
  input  logic               retire,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [LEN_W-1:0]   topLen,
  output strobe_t            st
);
  localparam logic [LEN_W-1:0] LEN_PERM = '1;

  cmd_e cmd;
  logic notEmpty;
  logic full;
  logic permTop;

  assign cmd      = cmd_e'(cmdOp);
  assign notEmpty = depth != '0;
  assign full     = depth == DEPTH_W'(DEPTH);
  assign permTop  = topLen == LEN_PERM;

  // priority: command, register write, branch, retirement
  always_comb begin
    st = '0;
    unique case (cmd)
      CMD_CLEAR: st.clearAll = 1'b1;
      CMD_PUSH: begin
        if (full) st.ovfSet = 1'b1;
        else      st.push   = 1'b1;
      end
      CMD_POP: begin
        if (notEmpty) st.popOne = 1'b1;
      end
      default: begin
        if (csrWrEn) begin
          if (notEmpty) st.csrWr = 1'b1;
        end else if (branchTaken) begin
          st.cutBranch = 1'b1;
        end else if (retire && notEmpty && !permTop) begin
          if (topLen <= LEN_W'(1)) st.popExpired = 1'b1;
          else                     st.decTop     = 1'b1;
        end
      end
    endcase
  end

  // R10: never more than one action in a cycle
  p_single_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st));

  // R10: a pending command blocks register writes and ageing
  p_cmd_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp != 2'd0) |-> !(st.csrWr || st.cutBranch || st.decTop || st.popExpired));
endmodule

// File: rtl/opage_stack.sv
module opage_stack
  import opage_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  entry_t             pushEntry,
  input  entry_t             csrEntry,
  output logic [DEPTH_W-1:0] depth,
  output entry_t             topEntry,
  output logic               overflow
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LEN_W-1:0] LEN_PERM = '1;

  entry_t [DEPTH-1:0] slotVec;
  logic   [IDX_W-1:0] topIdx;
  logic   [DEPTH_W-1:0] keepCnt;

  assign topIdx   = IDX_W'(depth - DEPTH_W'(1));
  assign topEntry = (depth == '0) ? entry_t'('0) : slotVec[topIdx];

  // length of the permanent run from the bottom, for branch truncation
  always_comb begin
    logic run;
    run     = 1'b1;
    keepCnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (run && (DEPTH_W'(i) < depth) && (slotVec[i].len == LEN_PERM))
        keepCnt = DEPTH_W'(i + 1);
      else
        run = 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    entry_t ent;
    logic   isTop;
    assign isTop = (depth != '0) && (topIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent <= '0;
      end else if (st.push && depth == DEPTH_W'(g)) begin
        ent <= pushEntry;
      end else if (st.csrWr && isTop) begin
        ent <= csrEntry;
      end else if (st.decTop && isTop) begin
        ent.len <= ent.len - LEN_W'(1);
      end
    end

    assign slotVec[g] = ent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
    end else if (st.clearAll) begin
      depth <= '0;
    end else if (st.push) begin
      depth <= depth + DEPTH_W'(1);
    end else if (st.popOne || st.popExpired) begin
      depth <= depth - DEPTH_W'(1);
    end else if (st.cutBranch) begin
      depth <= keepCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          overflow <= 1'b0;
    else if (st.ovfSet) overflow <= 1'b1;
  end

  p_depth_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(DEPTH));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.push |=> depth == $past(depth) + DEPTH_W'(1));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.ovfSet |=> (overflow && $stable(depth)));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  p_pop_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.popOne |=> depth == $past(depth) - DEPTH_W'(1));

  p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.clearAll |=> depth == '0);

  p_no_dec_perm_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.decTop |-> topEntry.len != LEN_PERM);

  p_cut_perm_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.cutBranch |=> (depth == '0 || topEntry.len == LEN_PERM));
endmodule

// File: rtl/opcode_page_stack.sv
module opcode_page_stack
  import opage_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cmdOp,
  input  logic [PAGE_W-1:0]  cmdPage,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic               retire,
  input  logic               branchTaken,
  input  logic               csrWrEn,
  input  logic [ENTRY_W-1:0] csrWrData,
  output logic [PAGE_W-1:0]  curPage,
  output logic [ENTRY_W-1:0] csrRdData,
  output logic [DEPTH_W-1:0] depth,
  output logic               overflow
);
  strobe_t st;
  entry_t  topEntry;
  entry_t  pushEntry;
  entry_t  csrEntry;

  assign pushEntry = '{page: cmdPage, len: cmdLen};
  assign csrEntry  = entry_t'(csrWrData);

  opage_ctrl #(.DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdOp      (cmdOp),
    .csrWrEn    (csrWrEn),
    .branchTaken(branchTaken),
    .retire     (retire),
    .depth      (depth),
    .topLen     (topEntry.len),
    .st         (st)
  );

  opage_stack #(.DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) uStack (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .pushEntry(pushEntry),
    .csrEntry (csrEntry),
    .depth    (depth),
    .topEntry (topEntry),
    .overflow (overflow)
  );

  assign curPage   = topEntry.page;
  assign csrRdData = topEntry;
endmodule

// File: tb/opcode_page_stack_test.sv
`timescale 1ns/1ps
module opcode_page_stack_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [2:0] cmdPage = '0;
  logic [3:0] cmdLen = '0;
  logic       retire = 1'b0;
  logic       branchTaken = 1'b0;
  logic       csrWrEn = 1'b0;
  logic [6:0] csrWrData = '0;
  logic [2:0] curPage;
  logic [6:0] csrRdData;
  logic [2:0] depth;
  logic       overflow;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  logic [6:0] mSlot [4];
  int         mDepth = 0;
  bit         mOvf = 0;

  always #2 clk = ~clk;

  opcode_page_stack uut (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdPage(cmdPage), .cmdLen(cmdLen),
    .retire(retire), .branchTaken(branchTaken), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .curPage(curPage), .csrRdData(csrRdData),
    .depth(depth), .overflow(overflow)
  );

  function automatic logic [6:0] expTop();
    return (mDepth > 0) ? mSlot[mDepth-1] : 7'd0;
  endfunction

  task automatic modelStep(input logic [1:0] op, input logic [2:0] pg,
                           input logic [3:0] ln, input bit ret, input bit br,
                           input bit wr, input logic [6:0] wd);
    if (op == 2'd3) mDepth = 0;
    else if (op == 2'd1) begin
      if (mDepth == 4) mOvf = 1;
      else begin mSlot[mDepth] = {pg, ln}; mDepth++; end
    end else if (op == 2'd2) begin
      if (mDepth > 0) mDepth--;
    end else if (wr) begin
      if (mDepth > 0) mSlot[mDepth-1] = wd;
    end else if (br) begin
      int k = 0;
      while (k < mDepth && mSlot[k][3:0] == 4'd15) k++;
      mDepth = k;
    end else if (ret && mDepth > 0) begin
      logic [3:0] l = mSlot[mDepth-1][3:0];
      if (l != 4'd15) begin
        if (l <= 4'd1) mDepth--;
        else mSlot[mDepth-1][3:0] = l - 4'd1;
      end
    end
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " depth"}, int'(depth), mDepth);
    chk({tag, " curPage"}, int'(curPage), int'(expTop() >> 4));
    chk({tag, " csrRdData"}, int'(csrRdData), int'(expTop()));
    chk({tag, " overflow"}, int'(overflow), int'(mOvf));
  endtask

  // drive at negedge, advance one edge, sample at next negedge
  task automatic cyc(input logic [1:0] op, input logic [2:0] pg, input logic [3:0] ln,
                     input bit ret, input bit br, input bit wr, input logic [6:0] wd);
    cmdOp = op; cmdPage = pg; cmdLen = ln; retire = ret; branchTaken = br;
    csrWrEn = wr; csrWrData = wd;
    modelStep(op, pg, ln, ret, br, wr, wd);
    @(negedge clk);
    cmdOp = '0; retire = 0; branchTaken = 0; csrWrEn = 0;
  endtask

  task automatic push(input logic [2:0] pg, input logic [3:0] ln);
    cyc(2'd1, pg, ln, 0, 0, 0, '0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1 reset");

    push(3'd5, 4'd3);
    chk("R2 push page", int'(curPage), 5);
    checkAll("R2 push");
    push(3'd2, 4'd15);
    push(3'd7, 4'd15);
    push(3'd1, 4'd2);
    checkAll("R2 fill");
    push(3'd3, 4'd9);
    chk("R3 overflow set", int'(overflow), 1);
    checkAll("R3 full push");

    cyc(0, 0, 0, 1, 0, 0, '0);
    chk("R6 decrement", int'(csrRdData), 7'h11);
    cyc(0, 0, 0, 1, 0, 0, '0);
    chk("R6 expired pop", int'(depth), 3);
    checkAll("R6 expire");
    repeat (5) cyc(0, 0, 0, 1, 0, 0, '0);
    chk("R7 permanent", int'(csrRdData), 7'h7F);
    checkAll("R7 hold");

    cyc(0, 0, 0, 0, 0, 1, 7'h3A);
    checkAll("R9 write top");
    cyc(0, 0, 0, 1, 0, 0, '0);
    chk("R9 written length ages", int'(csrRdData), 7'h39);

    cyc(2'd3, 0, 0, 0, 0, 0, '0);
    checkAll("R5 clear");
    chk("R3 sticky after clear", int'(overflow), 1);

    push(3'd2, 4'd15); push(3'd4, 4'd15); push(3'd6, 4'd5); push(3'd1, 4'd15);
    cyc(0, 0, 0, 0, 1, 0, '0);
    chk("R8 cut depth", int'(depth), 2);
    chk("R8 cut page", int'(curPage), 4);
    checkAll("R8 branch");

    cyc(2'd2, 0, 0, 0, 0, 0, '0);
    chk("R4 pop reveals", int'(csrRdData), 7'h2F);
    cyc(2'd2, 0, 0, 0, 0, 0, '0);
    cyc(2'd2, 0, 0, 0, 0, 0, '0);
    checkAll("R4 pop empty");
    cyc(0, 0, 0, 0, 0, 1, 7'h55);
    checkAll("R9 write empty");

    push(3'd3, 4'd0);
    cyc(0, 0, 0, 1, 0, 0, '0);
    checkAll("R6 length zero");

    push(3'd6, 4'd4);
    cyc(2'd1, 3'd5, 4'd15, 1, 1, 1, 7'h11);
    checkAll("R10 cmd wins");
    cyc(0, 0, 0, 1, 1, 1, 7'h26);
    checkAll("R10 write wins");
    cyc(0, 0, 0, 1, 1, 0, '0);
    checkAll("R10 branch wins");

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] op;
      int r = int'($urandom_range(0, 15));
      op = (r < 3) ? 2'd1 : (r < 5) ? 2'd2 : (r == 5) ? 2'd3 : 2'd0;
      cyc(op, 3'($urandom_range(0, 7)),
          ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(0, 15)),
          $urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0,
          $urandom_range(0, 11) == 0, 7'($urandom_range(0, 127)));
      checkAll("R10 random");
    end

    rstN = 0;
    mDepth = 0; mOvf = 0;
    @(negedge clk);
    checkAll("R1 mid reset");
    rstN = 1;
    @(negedge clk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule